// File: doc/BRIEF.md
# Protected Register Write Guard

This block watches a simple peripheral register bus and decides whether a write to one of a few special registers may take effect. A special register accepts a write only after an unlock step: software first writes any value to an unlock command register, and the next write then goes to the special register. The guard tracks this sequence and asserts a write strobe for the addressed special register only when the sequence is intact. It also keeps a sticky protection-fault flag in a status register, which software can read and clear.

There are two classes of special register. For the general class, plain reads between the unlock write and the special write are allowed. The watchdog-control register is stricter: any bus access between the two writes cancels the unlock. A bit-manipulation (read-modify-write) access always counts as a write. The register contents live outside the block. The guard gives a strobe that is valid in the same cycle as the bus write, and the peripheral latches the bus data on that strobe.

Top module: `prot_wr_guard`

## Requirements
- R1: After synchronous reset the fault flag is 0, the read data is 0x00 and no write strobe is active.
- R2: A read of the status register (address 0xFFFFF802) returns the fault flag in bit 0, with bits 7..1 at 0, one cycle after the read.
- R3: A command-register write (address 0xFFFFF1FC, any data) followed by a write to a special register asserts that register's strobe, and only that one, in the cycle of the special write. The fault flag is left unchanged.
- R4: A write to a special register that is not preceded by an unlock gets no strobe, and the fault flag is 1 from the next cycle.
- R5: Two command-register writes with no other write between them set the fault flag. The second command write leaves the unlock armed.
- R6: When the first write after a command write targets a register that is not special, the fault flag is set. The unlock is consumed, so a later special write is refused.
- R7: Writing 0 to bit 0 of the status register clears the flag and writing 1 sets it. Otherwise the flag stays set until reset.
- R8: A write of 0 to the status register made right after a command write leaves the flag at 0, because the status write wins. The unlock is consumed by it.
- R9: For the general special registers (0xFFFFF828 and 0xFFFFF82C), plain reads between the command write and the special write do not cancel the unlock.
- R10: For the watchdog-control register (0xFFFFF6D0), any access other than a read of the command register, made between the command write and the watchdog write, cancels the unlock. The watchdog write is then refused and sets the flag.
- R11: An access marked as bit-manipulation counts as a write, both for raising a fault and for strobing a special register.
- R12: A read of the command register returns 0 and does not change the unlock state for either class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_vld | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_bitop | input | 1 | Access is a bit-manipulation (read-modify-write); counts as a write |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for status and command registers, valid one cycle after a read |
| spec_we | output | 3 | Per-special-register write strobe; bit 0 is the watchdog-control register |
| prot_err | output | 1 | Sticky protection-fault flag |

## Verification
The write strobes are combinational and belong to the same cycle as the bus write. The fault flag and the read data are registered and appear one cycle after the access that causes them. Each bench access drives the bus on a falling edge and samples the strobe shortly after that edge, before the rising edge. It then samples the flag and the read data on the following falling edge, which falls after exactly one register stage. An idle cycle separates consecutive accesses, and idle cycles do not count as accesses, so they neither cancel nor consume the unlock.

// File: rtl/prot_guard_pkg.sv
// Package: shared constants for the protected register write guard.
// Assumes a 32-bit byte-addressed peripheral bus with 8-bit data.
package prot_guard_pkg;
    localparam int unsigned BUS_AW = 32;
    localparam int unsigned BUS_DW = 8;

    // Address decode result for one bus access
    typedef struct packed {
        logic is_cmd;
        logic is_stat;
        logic is_spec;
        logic is_wdt;
    } guard_hit_t;
endpackage

// File: rtl/guard_decode.sv
// Module: guard_decode
// Compares the bus address with the command, status and special-register
// addresses. Assumes the special addresses are distinct from each other and
// from the command and status addresses.
module guard_decode
    import prot_guard_pkg::*;
#(
    parameter int unsigned        AW         = BUS_AW,
    parameter int unsigned        NSPEC      = 3,
    parameter int unsigned        WDT_IDX    = 0,
    parameter logic [NSPEC*AW-1:0] SPEC_ADDRS = '0,
    parameter logic [AW-1:0]      CMD_ADDR   = '0,
    parameter logic [AW-1:0]      STAT_ADDR  = '0
) (
    input  logic [AW-1:0]    addr,
    output logic [NSPEC-1:0] spec_hit,
    output guard_hit_t       hit
);
    // One comparator per special register
    for (genvar i = 0; i < NSPEC; i++) begin : g_cmp
        assign spec_hit[i] = (addr == SPEC_ADDRS[i*AW +: AW]);
    end

    // Collapse the individual hits into the summary struct
    always_comb begin
        hit.is_cmd  = (addr == CMD_ADDR);
        hit.is_stat = (addr == STAT_ADDR);
        hit.is_spec = |spec_hit;
        hit.is_wdt  = spec_hit[WDT_IDX];
    end
endmodule

// File: rtl/guard_unlock.sv
// Module: guard_unlock
// Tracks the two-step unlock for both register classes and decides, for each
// write-class access, whether it is granted or is a protection violation.
// Assumes acc_wr already includes bit-manipulation accesses.
module guard_unlock
    import prot_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_vld,
    input  logic       acc_wr,
    input  guard_hit_t hit,
    output logic       arm_gen,
    output logic       arm_wdt,
    output logic       grant,
    output logic       viol
);
    logic wr_cls;
    logic rd_cls;

    // Classify the access
    always_comb begin
        wr_cls = acc_vld && acc_wr;
        rd_cls = acc_vld && !acc_wr;
    end

    // Grant or refuse the current write; any write while armed that is not a
    // granted special write counts as a violation
    always_comb begin
        grant = wr_cls && hit.is_spec && (hit.is_wdt ? arm_wdt : arm_gen);
        viol  = wr_cls && (hit.is_spec ? !grant : arm_gen);
    end

    // Arm on command writes, disarm on other writes, weaken on reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_gen <= 1'b0;
            arm_wdt <= 1'b0;
        end else if (wr_cls && hit.is_cmd) begin
            arm_gen <= 1'b1;
            arm_wdt <= 1'b1;
        end else if (wr_cls) begin
            arm_gen <= 1'b0;
            arm_wdt <= 1'b0;
        end else if (rd_cls && !hit.is_cmd) begin
            arm_wdt <= 1'b0;
        end
    end
endmodule

// File: rtl/guard_flag.sv
// Module: guard_flag
// Sticky protection-fault flag. A direct software write to the flag takes
// priority over a violation raised by the same access.
module guard_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_wr,
    input  logic stat_bit,
    input  logic viol,
    output logic flag
);
    // Hold, load from software, or set on violation
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (stat_wr) flag <= stat_bit;
        else if (viol)    flag <= 1'b1;
    end
endmodule

// File: rtl/prot_wr_guard.sv
// Module: prot_wr_guard (top)
// Guards writes to special registers behind a command-register unlock and
// reports faults in a status register. Assumes at most one bus access per
// cycle. Strobes are combinational with the bus write; read data and flag
// are registered.
module prot_wr_guard
    import prot_guard_pkg::*;
#(
    parameter int unsigned         AW         = BUS_AW,
    parameter int unsigned         DW         = BUS_DW,
    parameter int unsigned         NSPEC      = 3,
    parameter int unsigned         WDT_IDX    = 0,
    parameter logic [NSPEC*AW-1:0] SPEC_ADDRS = {32'hFFFF_F82C, 32'hFFFF_F828, 32'hFFFF_F6D0},
    parameter logic [AW-1:0]       CMD_ADDR   = 32'hFFFF_F1FC,
    parameter logic [AW-1:0]       STAT_ADDR  = 32'hFFFF_F802
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_vld,
    input  logic             bus_wr,
    input  logic             bus_bitop,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    rd_data,
    output logic [NSPEC-1:0] spec_we,
    output logic             prot_err
);
    localparam int unsigned PADW = DW - 1;

    guard_hit_t       hit;
    logic [NSPEC-1:0] spec_hit;
    logic             acc_wr;
    logic             arm_gen;
    logic             arm_wdt;
    logic             grant;
    logic             viol;
    logic             stat_wr;

    // Bit-manipulation accesses are write-class
    always_comb begin
        acc_wr  = bus_wr || bus_bitop;
        stat_wr = bus_vld && acc_wr && hit.is_stat;
    end

    guard_decode #(
        .AW(AW), .NSPEC(NSPEC), .WDT_IDX(WDT_IDX),
        .SPEC_ADDRS(SPEC_ADDRS), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR)
    ) u_dec (
        .addr(bus_addr), .spec_hit(spec_hit), .hit(hit)
    );

    guard_unlock u_unl (
        .clk(clk), .rst_n(rst_n), .acc_vld(bus_vld), .acc_wr(acc_wr),
        .hit(hit), .arm_gen(arm_gen), .arm_wdt(arm_wdt),
        .grant(grant), .viol(viol)
    );

    guard_flag u_flg (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr),
        .stat_bit(bus_wdata[0]), .viol(viol), .flag(prot_err)
    );

    // Per-register strobe gated by the grant
    for (genvar i = 0; i < NSPEC; i++) begin : g_we
        assign spec_we[i] = grant && spec_hit[i];
    end

    // Registered read data; only the status register returns non-zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (bus_vld && !acc_wr && hit.is_stat)
            rd_data <= {{PADW{1'b0}}, prot_err};
        else
            rd_data <= '0;
    end
endmodule

// File: rtl/prot_wr_guard_chk.sv
// Module: prot_wr_guard_chk
// Property checker for prot_wr_guard, attached with bind below.
module prot_wr_guard_chk #(
    parameter int unsigned   AW        = 32,
    parameter int unsigned   DW        = 8,
    parameter int unsigned   NSPEC     = 3,
    parameter int unsigned   WDT_IDX   = 0,
    parameter logic [AW-1:0] CMD_ADDR  = '0,
    parameter logic [AW-1:0] STAT_ADDR = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_vld,
    input logic             bus_wr,
    input logic             bus_bitop,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [DW-1:0]    rd_data,
    input logic [NSPEC-1:0] spec_we,
    input logic             prot_err,
    input logic             arm_gen,
    input logic             arm_wdt
);
    // R3
    strobe_needs_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|spec_we) |-> arm_gen);
    // R3
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spec_we));
    // R10
    wdt_strobe_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spec_we[WDT_IDX] |-> arm_wdt);
    // R7
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_err) |-> $past(bus_vld && (bus_wr || bus_bitop)));
    // R7
    flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_err) |-> $past(bus_vld && (bus_wr || bus_bitop)
                                  && bus_addr == STAT_ADDR && !bus_wdata[0]));
    // R12
    cmd_read_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !bus_wr && !bus_bitop && bus_addr == CMD_ADDR)
        |=> ($stable(arm_gen) && $stable(arm_wdt)));
    // R2
    rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:1] == '0);
endmodule

bind prot_wr_guard prot_wr_guard_chk #(
    .AW(AW), .DW(DW), .NSPEC(NSPEC), .WDT_IDX(WDT_IDX),
    .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_bitop(bus_bitop), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .spec_we(spec_we), .prot_err(prot_err),
    .arm_gen(arm_gen), .arm_wdt(arm_wdt)
);

// File: tb/tb_prot_wr_guard.sv
// Directed testbench for prot_wr_guard: one task per scenario.
module tb_prot_wr_guard;
    localparam logic [31:0] A_CMD  = 32'hFFFF_F1FC;
    localparam logic [31:0] A_STAT = 32'hFFFF_F802;
    localparam logic [31:0] A_WDT  = 32'hFFFF_F6D0;
    localparam logic [31:0] A_S1   = 32'hFFFF_F828;
    localparam logic [31:0] A_S2   = 32'hFFFF_F82C;
    localparam logic [31:0] A_PLN  = 32'hFFFF_F400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_vld = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_bitop = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic [2:0]  spec_we;
    logic        prot_err;

    int total = 0;
    int bad = 0;
    logic [2:0] we_s;
    logic [7:0] rd_s;
    logic       fl_s;

    always #4 clk = ~clk;

    prot_wr_guard dut (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
        .bus_bitop(bus_bitop), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .spec_we(spec_we), .prot_err(prot_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One access: strobe sampled in its cycle, flag/read data one cycle later
    task automatic acc(input logic wr, input logic bo, input logic [31:0] a,
                       input logic [7:0] d);
        @(negedge clk);
        bus_vld = 1'b1; bus_wr = wr; bus_bitop = bo; bus_addr = a; bus_wdata = d;
        #1 we_s = spec_we;
        @(negedge clk);
        rd_s = rd_data; fl_s = prot_err;
        bus_vld = 1'b0; bus_wr = 1'b0; bus_bitop = 1'b0;
    endtask

    task automatic clear_flag();
        acc(1'b1, 1'b0, A_STAT, 8'h00);
    endtask

    task automatic t_reset();
        check("R1 flag", int'(prot_err), 0);
        check("R1 rd_data", int'(rd_data), 0);
        check("R1 strobes", int'(spec_we), 0);
    endtask

    task automatic t_reads();
        acc(1'b0, 1'b0, A_STAT, 8'h00);
        check("R2 status read clean", int'(rd_s), 8'h00);
        acc(1'b0, 1'b0, A_CMD, 8'h00);
        check("R12 command read value", int'(rd_s), 0);
    endtask

    task automatic t_good_unlock();
        acc(1'b1, 1'b0, A_CMD, 8'hA5);
        acc(1'b1, 1'b0, A_S1, 8'h3C);
        check("R3 general strobe", int'(we_s), 3'b010);
        check("R3 flag kept", int'(fl_s), 0);
        acc(1'b1, 1'b0, A_CMD, 8'h00);
        acc(1'b1, 1'b0, A_WDT, 8'h11);
        check("R3 watchdog strobe", int'(we_s), 3'b001);
        check("R3 flag kept wdt", int'(fl_s), 0);
    endtask

    task automatic t_missing();
        acc(1'b1, 1'b0, A_S2, 8'h01);
        check("R4 refused strobe", int'(we_s), 0);
        check("R4 flag set", int'(fl_s), 1);
        acc(1'b0, 1'b0, A_STAT, 8'h00);
        check("R2 status read set", int'(rd_s), 8'h01);
        acc(1'b1, 1'b0, A_PLN, 8'h00);
        check("R7 sticky over plain write", int'(fl_s), 1);
        clear_flag();
        check("R7 clear by 0", int'(fl_s), 0);
        acc(1'b1, 1'b0, A_STAT, 8'h01);
        check("R7 set by 1", int'(fl_s), 1);
        clear_flag();
    endtask

    task automatic t_double();
        acc(1'b1, 1'b0, A_CMD, 8'h00);
        acc(1'b1, 1'b0, A_CMD, 8'hFF);
        check("R5 double command flag", int'(fl_s), 1);
        acc(1'b1, 1'b0, A_S1, 8'h00);
        check("R5 still armed", int'(we_s), 3'b010);
        clear_flag();
    endtask

    task automatic t_nonspec();
        acc(1'b1, 1'b0, A_CMD, 8'h00);
        acc(1'b1, 1'b0, A_PLN, 8'h55);
        check("R6 non-special flag", int'(fl_s), 1);
        clear_flag();
        acc(1'b1, 1'b0, A_S1, 8'h00);
        check("R6 unlock consumed", int'(we_s), 0);
        check("R6 refused flag", int'(fl_s), 1);
        clear_flag();
    endtask

    task automatic t_bitop();
        acc(1'b1, 1'b0, A_CMD, 8'h00);
        acc(1'b0, 1'b1, A_PLN, 8'h04);
        check("R11 bitop non-special flag", int'(fl_s), 1);
        clear_flag();
        acc(1'b1, 1'b0, A_CMD, 8'h00);
        acc(1'b1, 1'b1, A_S2, 8'h80);
        check("R11 bitop special strobe", int'(we_s), 3'b100);
        check("R11 bitop special flag", int'(fl_s), 0);
    endtask

    task automatic t_read_general();
        acc(1'b1, 1'b0, A_CMD, 8'h00);
        acc(1'b0, 1'b0, A_PLN, 8'h00);
        acc(1'b0, 1'b0, A_STAT, 8'h00);
        acc(1'b1, 1'b0, A_S1, 8'h22);
        check("R9 reads keep unlock", int'(we_s), 3'b010);
        check("R9 flag kept", int'(fl_s), 0);
    endtask

    task automatic t_read_wdt();
        acc(1'b1, 1'b0, A_CMD, 8'h00);
        acc(1'b0, 1'b0, A_PLN, 8'h00);
        acc(1'b1, 1'b0, A_WDT, 8'h22);
        check("R10 watchdog refused", int'(we_s), 0);
        check("R10 watchdog flag", int'(fl_s), 1);
        clear_flag();
        acc(1'b1, 1'b0, A_CMD, 8'h00);
        acc(1'b0, 1'b0, A_CMD, 8'h00);
        acc(1'b1, 1'b0, A_WDT, 8'h22);
        check("R12 command read keeps watchdog unlock", int'(we_s), 3'b001);
        check("R12 flag kept", int'(fl_s), 0);
    endtask

    task automatic t_clear_priority();
        acc(1'b1, 1'b0, A_S1, 8'h00);
        check("R8 precondition flag", int'(fl_s), 1);
        acc(1'b1, 1'b0, A_CMD, 8'h00);
        acc(1'b1, 1'b0, A_STAT, 8'h00);
        check("R8 clear wins", int'(fl_s), 0);
        acc(1'b1, 1'b0, A_S1, 8'h00);
        check("R8 unlock consumed", int'(we_s), 0);
        clear_flag();
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_good_unlock();
        t_missing();
        t_double();
        t_nonspec();
        t_bitop();
        t_read_general();
        t_read_wdt();
        t_clear_priority();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule